// File: doc/BRIEF.md
# Strap-Configured PHY Management Emulator

This block makes a bridge device answer an external Ethernet MAC as if it were an ordinary Ethernet PHY. While reset is held it captures a small set of configuration straps: two bits that choose its management address, and one bit each for link speed, duplex and isolation. These captured values become the power-up contents of the control register. The same values are also presented as steady configuration outputs to the MII datapath. That datapath must tri-state its receive data, receive valid, receive error, collision, carrier-sense and both clock outputs, and must ignore its transmit inputs, while the isolate output is high.

The MAC reaches the control, status and two identifier registers through the usual two-wire management interface. It sends the clock and a serial frame made of a preamble of ones, a start code, an opcode, a PHY address, a register index, a turnaround and sixteen data bits. The block samples the management clock with its own system clock, so the management clock must be several times slower than the system clock. Auto-negotiation is never offered. A local firmware port can overwrite the control register at any time after reset.

Top module: `phy_emu_mdio`

## Requirements
- R1: The management address is {strap_addr[1], strap_addr[0], 3'b000}: strap values 0, 1, 2 and 3 give addresses 0x00, 0x08, 0x10 and 0x18. A frame that carries any other PHY address is ignored entirely. A read to another address leaves MDIO undriven. A write to another address leaves the control register unchanged.
- R2: On the first cycle after reset, register 0 holds strap_speed in bit 13, strap_isolate in bit 10 and strap_duplex in bit 8, and every other bit is zero. cfg_speed100, cfg_isolate and cfg_full_duplex equal bits 13, 10 and 8 of register 0 at all times.
- R3: Straps, including the address straps, are sampled only while rst is high. Changing them after reset has no effect on the registers or on the address.
- R4: Register 1 (status) always reads 16'h7805. This value reports all four 10/100 half/full abilities in bits 14 to 11, link up in bit 2 and extended capability in bit 0. Bit 3 is zero, so auto-negotiation is reported as unavailable.
- R5: Register 2 reads parameter ID_HI, register 3 reads parameter ID_LO, and every register index from 4 to 31 reads 0.
- R6: A management write to register 0 with bit 15 clear stores bits 13, 10 and 8 only. The auto-negotiation enable bit (12), the restart bit (9) and all other bits read back as zero.
- R7: A management write to register 0 with bit 15 set restores the strap values captured at the last reset, and bit 15 reads back as zero.
- R8: MDIO is driven only during a read frame that matches the address. The block drives 0 in the second turnaround bit and then data bits 15 down to 0, each bit changing after a rising MDC edge. It releases MDIO after the rising edge of the last data bit, and leaves it undriven during the first turnaround bit and at all other times.
- R9: A one-cycle fw_we pulse loads the control register with fw_wdata masked to bits 13, 10 and 8 on the next clock. fw_rdata always shows the current register 0 value. If fw_we and a management write complete in the same cycle, the firmware value is kept.
- R10: A frame is accepted only after at least PRE_LEN consecutive ones on MDIO followed by the start code 0 then 1. A frame with a shorter preamble is ignored.
- R11: Management writes to any register other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples MDC |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_speed | input | 1 | Speed strap: 1 = 100 Mb/s, 0 = 10 Mb/s |
| strap_duplex | input | 1 | Duplex strap: 1 = full, 0 = half |
| strap_isolate | input | 1 | Isolate strap: 1 = isolated, 0 = normal |
| strap_addr | input | 2 | Address straps, giving management address bits 4:3 |
| mdc | input | 1 | Management clock from the MAC |
| mdio_i | input | 1 | Management data as seen on the bus |
| mdio_o | output | 1 | Management data driven by this block |
| mdio_oe | output | 1 | Enable for mdio_o onto the bus |
| fw_we | input | 1 | Local firmware write strobe for register 0 |
| fw_wdata | input | 16 | Local firmware write data |
| fw_rdata | output | 16 | Current register 0 value |
| cfg_isolate | output | 1 | Isolate the MII datapath |
| cfg_speed100 | output | 1 | 100 Mb/s selected |
| cfg_full_duplex | output | 1 | Full duplex selected |

## Verification
The hardest case to reach from the ports is the edge of the drive window. The block must release the bus during the first turnaround bit and take it in the second, and it must release it again just after the last data bit. Otherwise a driver conflict goes unseen. The bench models the bus as a pulled-up line shared by the MAC model and the block. It samples the line at every rising MDC edge, so a slave that drives one bit too early or too late shows up as a wrong turnaround or data value. Separately, a per-clock monitor requires mdio_oe low through all writes, all mismatched reads and short-preamble frames. Strap capture is checked across several reset cycles with different strap patterns, and after each one the live straps are moved to make sure they are ignored.

// File: rtl/phy_emu_pkg.sv
package phy_emu_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;

  // control register bit positions (decoded by the MAC side)
  localparam int CB_RESET  = 15;
  localparam int CB_SPEED  = 13;
  localparam int CB_ISO    = 10;
  localparam int CB_DUPLEX = 8;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  // abilities: 100 FD, 100 HD, 10 FD, 10 HD; link up; extended capability
  localparam logic [REG_W-1:0] STATUS_WORD =
      (16'h1 << 14) | (16'h1 << 13) | (16'h1 << 12) | (16'h1 << 11) |
      (16'h1 << 2)  | 16'h1;

  typedef enum logic [2:0] {FS_PRE, FS_ST, FS_HDR, FS_TA, FS_DAT} frm_state_t;

  typedef struct packed {
    logic speed;
    logic iso;
    logic duplex;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[CB_SPEED]  = c.speed;
    w[CB_ISO]    = c.iso;
    w[CB_DUPLEX] = c.duplex;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.speed  = w[CB_SPEED];
    c.iso    = w[CB_ISO];
    c.duplex = w[CB_DUPLEX];
    return c;
  endfunction
endpackage

// File: rtl/phy_emu_sync.sv
module phy_emu_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phy_emu_mdio_fsm.sv
module phy_emu_mdio_fsm
  import phy_emu_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc_s,
  input  logic              mdio_s,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [REG_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              rd_hit,
  output logic              wr_stb,
  output logic [REG_W-1:0]  wr_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int PCW   = $clog2(PRE_LEN + 1);
  localparam int HDR_W = 2 + 2 * ADDR_W;
  localparam int CNT_W = $clog2(REG_W + 1);

  frm_state_t         st;
  logic               mdc_q;
  logic               rise;
  logic [PCW-1:0]     pre_cnt;
  logic [HDR_W-2:0]   hdr;
  logic [HDR_W-1:0]   hdr_n;
  logic [CNT_W-1:0]   cnt;
  logic               wr_hit;
  logic [REG_W-1:0]   rd_sh;
  logic [REG_W-2:0]   wsh;
  logic [REG_W-1:0]   wsh_n;
  logic               addr_ok;

  assign rise    = mdc_s & ~mdc_q;
  assign hdr_n   = {hdr, mdio_s};
  assign wsh_n   = {wsh, mdio_s};
  assign addr_ok = (hdr_n[2*ADDR_W-1 -: ADDR_W] == phy_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_PRE;
      mdc_q   <= 1'b0;
      pre_cnt <= '0;
      hdr     <= '0;
      cnt     <= '0;
      reg_idx <= '0;
      rd_hit  <= 1'b0;
      wr_hit  <= 1'b0;
      rd_sh   <= '0;
      wsh     <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      mdc_q  <= mdc_s;
      wr_stb <= 1'b0;
      if (rise) begin
        case (st)
          FS_PRE: begin
            if (mdio_s) begin
              if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PCW'(PRE_LEN)) st <= FS_ST;
              pre_cnt <= '0;
            end
          end
          FS_ST: begin
            cnt <= '0;
            hdr <= '0;
            st  <= mdio_s ? FS_HDR : FS_PRE;
          end
          FS_HDR: begin
            hdr <= hdr_n[HDR_W-2:0];
            if (cnt == CNT_W'(HDR_W - 1)) begin
              reg_idx <= hdr_n[ADDR_W-1:0];
              rd_hit  <= (hdr_n[HDR_W-1 -: 2] == OP_RD) && addr_ok;
              wr_hit  <= (hdr_n[HDR_W-1 -: 2] == OP_WR) && addr_ok;
              cnt     <= '0;
              st      <= FS_TA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FS_TA: begin
            if (cnt == '0) begin
              cnt   <= CNT_W'(1);
              rd_sh <= rd_data;
              if (rd_hit) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt <= '0;
              st  <= FS_DAT;
              if (rd_hit) begin
                mdio_o <= rd_sh[REG_W-1];
                rd_sh  <= {rd_sh[REG_W-2:0], 1'b0};
              end
            end
          end
          FS_DAT: begin
            wsh <= wsh_n[REG_W-2:0];
            if (cnt == CNT_W'(REG_W - 1)) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b1;
              wr_stb  <= wr_hit;
              wr_data <= wsh_n;
              rd_hit  <= 1'b0;
              wr_hit  <= 1'b0;
              pre_cnt <= '0;
              cnt     <= '0;
              st      <= FS_PRE;
            end else begin
              cnt <= cnt + 1'b1;
              if (rd_hit) begin
                mdio_o <= rd_sh[REG_W-1];
                rd_sh  <= {rd_sh[REG_W-2:0], 1'b0};
              end
            end
          end
          default: st <= FS_PRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_emu_regs.sv
module phy_emu_regs
  import phy_emu_pkg::*;
#(
  parameter logic [REG_W-1:0] ID_HI = 16'h1A2B,
  parameter logic [REG_W-1:0] ID_LO = 16'h3C40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_speed,
  input  logic              strap_duplex,
  input  logic              strap_isolate,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_reg,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              fw_we,
  input  logic [REG_W-1:0]  fw_wdata,
  input  logic [ADDR_W-1:0] rd_reg,
  output logic [REG_W-1:0]  rd_data,
  output logic [REG_W-1:0]  ctrl_word,
  output logic              cfg_isolate,
  output logic              cfg_speed100,
  output logic              cfg_full_duplex
);
  ctrl_t ctrl_q;
  ctrl_t dflt_q;
  logic  unused_bits;

  assign unused_bits = ^{wr_data, fw_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_q <= '{speed: strap_speed, iso: strap_isolate, duplex: strap_duplex};
      ctrl_q <= '{speed: strap_speed, iso: strap_isolate, duplex: strap_duplex};
    end else if (fw_we) begin
      ctrl_q <= unpack_ctrl(fw_wdata);
    end else if (wr_stb && (wr_reg == '0)) begin
      if (wr_data[CB_RESET]) ctrl_q <= dflt_q;
      else                   ctrl_q <= unpack_ctrl(wr_data);
    end
  end

  assign ctrl_word       = pack_ctrl(ctrl_q);
  assign cfg_isolate     = ctrl_q.iso;
  assign cfg_speed100    = ctrl_q.speed;
  assign cfg_full_duplex = ctrl_q.duplex;

  always_comb begin
    case (rd_reg)
      5'd0:    rd_data = ctrl_word;
      5'd1:    rd_data = STATUS_WORD;
      5'd2:    rd_data = ID_HI;
      5'd3:    rd_data = ID_LO;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/phy_emu_mdio.sv
module phy_emu_mdio
  import phy_emu_pkg::*;
#(
  parameter int               PRE_LEN     = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] ID_HI       = 16'h1A2B,
  parameter logic [REG_W-1:0] ID_LO       = 16'h3C40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_speed,
  input  logic        strap_duplex,
  input  logic        strap_isolate,
  input  logic [1:0]  strap_addr,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        fw_we,
  input  logic [15:0] fw_wdata,
  output logic [15:0] fw_rdata,
  output logic        cfg_isolate,
  output logic        cfg_speed100,
  output logic        cfg_full_duplex
);
  logic              mdc_s;
  logic              mdio_s;
  logic [ADDR_W-1:0] phy_addr;
  logic [ADDR_W-1:0] reg_idx;
  logic [REG_W-1:0]  rd_data;
  logic              rd_hit;
  logic              wr_stb;
  logic [REG_W-1:0]  wr_data;

  always_ff @(posedge clk) begin
    if (rst) phy_addr <= {strap_addr[1], strap_addr[0], 3'b000};
  end

  phy_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mdc (
    .clk(clk), .rst(rst), .d(mdc), .q(mdc_s));

  phy_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mdio (
    .clk(clk), .rst(rst), .d(mdio_i), .q(mdio_s));

  phy_emu_mdio_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
    .clk(clk), .rst(rst), .mdc_s(mdc_s), .mdio_s(mdio_s),
    .phy_addr(phy_addr), .rd_data(rd_data), .reg_idx(reg_idx),
    .rd_hit(rd_hit), .wr_stb(wr_stb), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  phy_emu_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk(clk), .rst(rst),
    .strap_speed(strap_speed), .strap_duplex(strap_duplex),
    .strap_isolate(strap_isolate),
    .wr_stb(wr_stb), .wr_reg(reg_idx), .wr_data(wr_data),
    .fw_we(fw_we), .fw_wdata(fw_wdata),
    .rd_reg(reg_idx), .rd_data(rd_data), .ctrl_word(fw_rdata),
    .cfg_isolate(cfg_isolate), .cfg_speed100(cfg_speed100),
    .cfg_full_duplex(cfg_full_duplex));
endmodule

// File: rtl/phy_emu_mdio_chk.sv
module phy_emu_mdio_chk (
  input logic        clk,
  input logic        rst,
  input logic        strap_speed,
  input logic        strap_duplex,
  input logic        strap_isolate,
  input logic [4:0]  phy_addr,
  input logic        mdio_oe,
  input logic        rd_hit,
  input logic        fw_we,
  input logic [15:0] fw_wdata,
  input logic [15:0] fw_rdata,
  input logic        cfg_speed100,
  input logic        cfg_full_duplex,
  input logic        cfg_isolate
);
  // R3: address only moves while reset is held
  p_addr_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(phy_addr));

  // R8: bus driven only inside a matching read
  p_oe_in_read_r8: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> rd_hit);

  // R2: first cycle after reset reflects the captured straps
  p_reset_defaults_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_speed100 == $past(strap_speed)) &&
                   (cfg_full_duplex == $past(strap_duplex)) &&
                   (cfg_isolate == $past(strap_isolate)));

  // R6: unsupported control bits always read zero
  p_ctrl_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (fw_rdata & 16'hDAFF) == 16'h0000);

  // R9: firmware write lands on the next clock
  p_fw_write_r9: assert property (@(posedge clk) disable iff (rst)
    fw_we |=> fw_rdata == ($past(fw_wdata) & 16'h2500));
endmodule

bind phy_emu_mdio phy_emu_mdio_chk u_chk (
  .clk(clk), .rst(rst), .strap_speed(strap_speed), .strap_duplex(strap_duplex),
  .strap_isolate(strap_isolate), .phy_addr(phy_addr), .mdio_oe(mdio_oe),
  .rd_hit(rd_hit), .fw_we(fw_we), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
  .cfg_speed100(cfg_speed100), .cfg_full_duplex(cfg_full_duplex),
  .cfg_isolate(cfg_isolate));

// File: tb/phy_emu_mdio_bench.sv
module phy_emu_mdio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam logic [15:0] IDH = 16'h1A2B;
  localparam logic [15:0] IDL = 16'h3C40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_speed = 1'b1, strap_duplex = 1'b1, strap_isolate = 1'b1;
  logic [1:0] strap_addr = 2'b01;
  logic mdc = 1'b0;
  logic mac_en = 1'b0, mac_bit = 1'b1;
  logic mdio_i, mdio_o, mdio_oe;
  logic fw_we = 1'b0;
  logic [15:0] fw_wdata = '0;
  logic [15:0] fw_rdata;
  logic cfg_isolate, cfg_speed100, cfg_full_duplex;

  int checks = 0, errors = 0;
  bit mon_en = 0, rd_win = 0, done = 0;
  logic [15:0] m_ctrl, m_dflt;
  logic [4:0]  m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pulled-up shared line
  assign mdio_i = mdio_oe ? mdio_o : (mac_en ? mac_bit : 1'b1);

  phy_emu_mdio #(.ID_HI(IDH), .ID_LO(IDL)) u_phy_emu_mdio (
    .clk(clk), .rst(rst), .strap_speed(strap_speed), .strap_duplex(strap_duplex),
    .strap_isolate(strap_isolate), .strap_addr(strap_addr), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .fw_we(fw_we),
    .fw_wdata(fw_wdata), .fw_rdata(fw_rdata), .cfg_isolate(cfg_isolate),
    .cfg_speed100(cfg_speed100), .cfg_full_duplex(cfg_full_duplex));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk("R2_R6 cfg", {cfg_speed100, cfg_isolate, cfg_full_duplex},
          {m_ctrl[13], m_ctrl[10], m_ctrl[8]});
      chk("R9 fw_rdata", fw_rdata, m_ctrl);
    end
    if (!rst && !rd_win && !done) chk("R8 idle oe", mdio_oe, 1'b0);
  end

  function automatic logic [15:0] exp_reg(input int r);
    case (r)
      0: return m_ctrl;
      1: return 16'h7805;
      2: return IDH;
      3: return IDL;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic do_reset(input logic spd, input logic dup, input logic iso, input logic [1:0] a);
    @(negedge clk);
    mon_en = 0;
    strap_speed = spd; strap_duplex = dup; strap_isolate = iso; strap_addr = a;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_dflt = (16'(spd) << 13) | (16'(iso) << 10) | (16'(dup) << 8);
    m_ctrl = m_dflt;
    m_addr = {a, 3'b000};
    @(negedge clk);
    chk("R2 reset value", fw_rdata, m_dflt);
    mon_en = 1;
  endtask

  task automatic mdc_bit(input logic en, input logic val, output logic s);
    mac_en = en; mac_bit = val; mdc = 0;
    repeat (HALF) @(negedge clk);
    mdc = 1;
    s = mdio_i;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd,
                       output logic ta1, output logic ta2, output logic [15:0] rd);
    logic s;
    logic [13:0] hdr;
    logic rdop;
    rdop = (op == 2'b10);
    hdr = {2'b01, op, pa, ra};
    for (int i = 0; i < pre; i++) mdc_bit(1, 1, s);
    for (int i = 13; i >= 0; i--) mdc_bit(1, hdr[i], s);
    mdc_bit(!rdop, 1'b1, ta1);
    mdc_bit(!rdop, 1'b0, ta2);
    for (int i = 15; i >= 0; i--) begin
      mdc_bit(!rdop, wd[i], s);
      rd[i] = s;
    end
    mac_en = 0; mdc = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic [4:0] pa, input logic [4:0] ra);
    logic t1, t2;
    logic [15:0] d;
    bit hit;
    hit = (pa == m_addr);
    rd_win = hit;
    frame(32, 2'b10, pa, ra, 16'h0, t1, t2, d);
    rd_win = 0;
    if (hit) begin
      chk({req, " data"}, d, exp_reg(int'(ra)));
      chk("R8 ta1 released", t1, 1'b1);
      chk("R8 ta2 driven low", t2, 1'b0);
    end else begin
      chk({req, " mismatch undriven"}, {t2, d}, 17'h1FFFF);
    end
  endtask

  task automatic do_write(input int pre, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic t1, t2;
    logic [15:0] d;
    mon_en = 0;
    frame(pre, 2'b01, pa, ra, wd, t1, t2, d);
    if (pre >= 32 && pa == m_addr && ra == 5'd0)
      m_ctrl = wd[15] ? m_dflt : (wd & 16'h2500);
    mon_en = 1;
  endtask

  task automatic fw_write(input logic [15:0] v);
    mon_en = 0;
    @(negedge clk);
    fw_we = 1; fw_wdata = v;
    @(negedge clk);
    fw_we = 0;
    m_ctrl = v & 16'h2500;
    chk("R9 fw write", fw_rdata, m_ctrl);
    mon_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ctrl = '0; m_dflt = '0; m_addr = '0;
    // default straps: addr 0x08, 100M, full, isolated
    do_reset(1, 1, 1, 2'b01);
    do_read("R2", 5'h08, 5'd0);
    do_read("R4", 5'h08, 5'd1);
    do_read("R5", 5'h08, 5'd2);
    do_read("R5", 5'h08, 5'd3);
    do_read("R5", 5'h08, 5'd7);
    do_read("R5", 5'h08, 5'd31);
    // R3: move live straps, nothing changes
    @(negedge clk);
    strap_addr = 2'b11; strap_speed = 0; strap_duplex = 0; strap_isolate = 0;
    do_read("R3", 5'h08, 5'd0);
    do_read("R3", 5'h18, 5'd0);
    // R1: other address ignored
    do_read("R1", 5'h00, 5'd0);
    do_write(32, 5'h10, 5'd0, 16'h0000);
    do_read("R1", 5'h08, 5'd0);
    // R6: AN bits ignored, stored bits update
    do_write(32, 5'h08, 5'd0, 16'h1200);
    do_read("R6", 5'h08, 5'd0);
    do_write(32, 5'h08, 5'd0, 16'h7FFF);
    do_read("R6", 5'h08, 5'd0);
    do_write(32, 5'h08, 5'd0, 16'h2100);
    do_read("R6", 5'h08, 5'd0);
    // R11: other registers not writable
    do_write(32, 5'h08, 5'd4, 16'hFFFF);
    do_write(32, 5'h08, 5'd1, 16'h0000);
    do_read("R11", 5'h08, 5'd4);
    do_read("R11", 5'h08, 5'd1);
    do_read("R11", 5'h08, 5'd0);
    // R10: short preamble rejected
    do_write(10, 5'h08, 5'd0, 16'h0400);
    do_read("R10", 5'h08, 5'd0);
    // R7: reset bit restores captured straps
    do_write(32, 5'h08, 5'd0, 16'h8000);
    do_read("R7", 5'h08, 5'd0);
    // R9: firmware override
    fw_write(16'hFFFF);
    do_read("R9", 5'h08, 5'd0);
    fw_write(16'h0100);
    do_read("R9", 5'h08, 5'd0);
    // R1 and R2 across strap patterns
    for (int a = 0; a < 4; a++) begin
      do_reset(logic'(a[0]), logic'(a[1]), logic'(~a[0]), 2'(a));
      do_read("R1", 5'(a * 8), 5'd0);
      do_read("R1", 5'((a * 8 + 8) % 32), 5'd0);
      do_write(32, 5'(a * 8), 5'd0, 16'h0500);
      do_read("R6", 5'(a * 8), 5'd0);
      do_write(32, 5'(a * 8), 5'd0, 16'h8000);
      do_read("R7", 5'(a * 8), 5'd0);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule